// File: doc/BRIEF.md
# Frequency-Locked Loop Controller

This block holds a digitally controlled oscillator at a programmed multiple of a slow reference clock. A divider in the reference domain cuts the reference into measurement windows of `REF_DIV` reference cycles. By default that is 16 cycles, which gives a 2048 Hz window rate from a 32.768 kHz reference. A counter clocked by the oscillator counts oscillator cycles in each window. The count crosses back into the reference domain through a toggle handshake. A small state machine then compares the count with the target, which is the programmed set value plus one. After each window it moves an 18-bit oscillator control code by one step toward the target.

The host loads the 13-bit set value in two writes. A high-part write only stages its bits. The following low-byte write commits the staged high part and the new low byte together, so the loop never sees a target that is half updated. When the loop is disabled, the control code freezes. On re-enable the loop continues from the frozen code, so there is no restart transient.

The loop state machine has three states. LP_OFF is idle while the loop is disabled. LP_WAIT waits for a window count. LP_EVAL applies one correction. The transitions are:

- LP_OFF to LP_WAIT when enabled.
- LP_WAIT to LP_EVAL when a new count arrives.
- LP_EVAL to LP_WAIT after the update.
- Any state to LP_OFF when the enable drops.

Top module: `fll_ctrl`

## Requirements
- R1: After reset the control code equals `CODE_RST` (default 131072). The set value equals `SET_RST` (default 4095, which gives a target of 4096 cycles per window).
- R2: A window lasts `REF_DIV` reference cycles. The control code changes at most once per window, and only in the cycle after the LP_EVAL state.
- R3: On each update the code moves by exactly `STEP` (default 1). It moves up when the window count is below set value + 1, moves down when the count is above it, and holds when they are equal.
- R4: Code saturates at its maximum (all ones) and never wraps to zero.
- R5: Code saturates at zero and never wraps to all ones.
- R6: When `wr_en` is high with `wr_sel`=0, `wr_data[4:0]` is staged as set bits 12:8 and the active target does not change. When `wr_en` is high with `wr_sel`=1, the set value becomes {staged bits 12:8, `wr_data[7:0]`}.
- R7: While `loop_en` is low, the control code holds its value. After re-enable, updates start from the held value.
- R8: With an oscillator whose frequency rises with the code, the oscillator cycles per window settle to within one of set value + 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock, also the register-write clock |
| ref_rst_n | input | 1 | Active-low asynchronous reset, reference domain |
| osc_clk | input | 1 | Oscillator clock being measured |
| osc_rst_n | input | 1 | Active-low asynchronous reset, oscillator domain |
| loop_en | input | 1 | Loop enable; low freezes the control code |
| wr_en | input | 1 | Set-value write strobe |
| wr_sel | input | 1 | 0 = stage the high part, 1 = commit with the low byte |
| wr_data | input | 8 | Write data |
| dco_code | output | CODE_W | Oscillator control code |

## Verification
The hardest situations to reach from the ports are the two saturation limits. A realistic oscillator model would need hundreds of thousands of windows to drive an 18-bit code to either end. The bench therefore adds a second instance with an 8-bit code, fed by a fixed-rate oscillator. It programs a target far above the fixed count to drive the code into its ceiling. It then commits a target of one to drive the code down to zero. A per-cycle model tracks the expected direction of movement through the exact cycle at which the new target takes effect. The staged-write check parks a locked loop and then writes only a high part that would move the target far away. It confirms the code stays put until the low byte commits.

// File: rtl/fll_pkg.sv
package fll_pkg;
    typedef enum logic [1:0] {
        LP_OFF  = 2'd0,
        LP_WAIT = 2'd1,
        LP_EVAL = 2'd2
    } lp_state_e;
endpackage

// File: rtl/fll_ref_tick.sv
module fll_ref_tick #(
    parameter int unsigned REF_DIV = 16
) (
    input  logic ref_clk,
    input  logic ref_rst_n,
    output logic win_tgl
);
    localparam int unsigned DW = (REF_DIV > 2) ? $clog2(REF_DIV) : 1;

    logic [DW-1:0] div_q;

    always_ff @(posedge ref_clk or negedge ref_rst_n) begin
        if (!ref_rst_n) begin
            div_q   <= '0;
            win_tgl <= 1'b0;
        end else if (div_q == DW'(REF_DIV - 1)) begin
            div_q   <= '0;
            win_tgl <= ~win_tgl;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end
endmodule

// File: rtl/fll_osc_count.sv
module fll_osc_count #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             osc_clk,
    input  logic             osc_rst_n,
    input  logic             win_tgl,
    output logic [CNT_W-1:0] cap_cnt,
    output logic             cap_tgl
);
    logic [2:0]       win_sync;
    logic             win_edge;
    logic [CNT_W-1:0] run_cnt;

    assign win_edge = win_sync[2] ^ win_sync[1];

    always_ff @(posedge osc_clk or negedge osc_rst_n) begin
        if (!osc_rst_n) begin
            win_sync <= '0;
            run_cnt  <= '0;
            cap_cnt  <= '0;
            cap_tgl  <= 1'b0;
        end else begin
            win_sync <= {win_sync[1:0], win_tgl};
            if (win_edge) begin
                cap_cnt <= run_cnt;
                cap_tgl <= ~cap_tgl;
                run_cnt <= CNT_W'(1);
            end else if (run_cnt != '1) begin
                run_cnt <= run_cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/fll_set_reg.sv
module fll_set_reg #(
    parameter int unsigned SET_W   = 13,
    parameter int unsigned SET_RST = 4095
) (
    input  logic             ref_clk,
    input  logic             ref_rst_n,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [7:0]       wr_data,
    output logic [SET_W-1:0] set_q
);
    localparam int unsigned HI_W = SET_W - 8;
    localparam logic [SET_W-1:0] RSTV = SET_W'(SET_RST);

    logic [HI_W-1:0] hi_stage;

    always_ff @(posedge ref_clk or negedge ref_rst_n) begin
        if (!ref_rst_n) begin
            hi_stage <= RSTV[SET_W-1:8];
            set_q    <= RSTV;
        end else if (wr_en) begin
            if (!wr_sel) hi_stage <= wr_data[HI_W-1:0];
            else         set_q    <= {hi_stage, wr_data};
        end
    end
endmodule

// File: rtl/fll_loop.sv
module fll_loop
    import fll_pkg::*;
#(
    parameter int unsigned CODE_W   = 18,
    parameter int unsigned CNT_W    = 16,
    parameter int unsigned SET_W    = 13,
    parameter int unsigned STEP     = 1,
    parameter int unsigned CODE_RST = 131072
) (
    input  logic              ref_clk,
    input  logic              ref_rst_n,
    input  logic              loop_en,
    input  logic [CNT_W-1:0]  cap_cnt,
    input  logic              cap_tgl,
    input  logic [SET_W-1:0]  set_q,
    output logic [CODE_W-1:0] code_q,
    output lp_state_e         state_q
);
    localparam logic [CODE_W-1:0] MAXC  = '1;
    localparam logic [CODE_W-1:0] STEPC = CODE_W'(STEP);

    lp_state_e         state_d;
    logic [2:0]        cap_sync;
    logic              arrive;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  target;
    logic [CODE_W-1:0] code_d;

    assign arrive = cap_sync[2] ^ cap_sync[1];
    assign target = CNT_W'(set_q) + CNT_W'(1);

    always_ff @(posedge ref_clk or negedge ref_rst_n) begin
        if (!ref_rst_n) state_q <= LP_OFF;
        else            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        code_d  = code_q;
        unique case (state_q)
            LP_OFF:  if (loop_en) state_d = LP_WAIT;
            LP_WAIT: begin
                if (!loop_en)    state_d = LP_OFF;
                else if (arrive) state_d = LP_EVAL;
            end
            LP_EVAL: begin
                if (!loop_en) begin
                    state_d = LP_OFF;
                end else begin
                    state_d = LP_WAIT;
                    if (cnt_q > target)
                        code_d = (code_q < STEPC) ? '0 : code_q - STEPC;
                    else if (cnt_q < target)
                        code_d = (code_q > MAXC - STEPC) ? MAXC : code_q + STEPC;
                end
            end
            default: state_d = LP_OFF;
        endcase
    end

    always_ff @(posedge ref_clk or negedge ref_rst_n) begin
        if (!ref_rst_n) begin
            cap_sync <= '0;
            cnt_q    <= '0;
            code_q   <= CODE_W'(CODE_RST);
        end else begin
            cap_sync <= {cap_sync[1:0], cap_tgl};
            if (arrive) cnt_q <= cap_cnt;
            code_q <= code_d;
        end
    end
endmodule

// File: rtl/fll_ctrl.sv
module fll_ctrl
    import fll_pkg::*;
#(
    parameter int unsigned CODE_W   = 18,
    parameter int unsigned CODE_RST = 131072,
    parameter int unsigned SET_W    = 13,
    parameter int unsigned SET_RST  = 4095,
    parameter int unsigned REF_DIV  = 16,
    parameter int unsigned STEP     = 1
) (
    input  logic              ref_clk,
    input  logic              ref_rst_n,
    input  logic              osc_clk,
    input  logic              osc_rst_n,
    input  logic              loop_en,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [7:0]        wr_data,
    output logic [CODE_W-1:0] dco_code
);
    localparam int unsigned CNT_W = SET_W + 3;

    logic             win_tgl;
    logic [CNT_W-1:0] cap_cnt;
    logic             cap_tgl;
    logic [SET_W-1:0] set_q;
    lp_state_e        lp_state;

    fll_ref_tick #(.REF_DIV(REF_DIV)) u_tick (
        .ref_clk(ref_clk), .ref_rst_n(ref_rst_n), .win_tgl(win_tgl)
    );

    fll_osc_count #(.CNT_W(CNT_W)) u_cnt (
        .osc_clk(osc_clk), .osc_rst_n(osc_rst_n), .win_tgl(win_tgl),
        .cap_cnt(cap_cnt), .cap_tgl(cap_tgl)
    );

    fll_set_reg #(.SET_W(SET_W), .SET_RST(SET_RST)) u_set (
        .ref_clk(ref_clk), .ref_rst_n(ref_rst_n), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .set_q(set_q)
    );

    fll_loop #(
        .CODE_W(CODE_W), .CNT_W(CNT_W), .SET_W(SET_W),
        .STEP(STEP), .CODE_RST(CODE_RST)
    ) u_loop (
        .ref_clk(ref_clk), .ref_rst_n(ref_rst_n), .loop_en(loop_en),
        .cap_cnt(cap_cnt), .cap_tgl(cap_tgl), .set_q(set_q),
        .code_q(dco_code), .state_q(lp_state)
    );
endmodule

// File: rtl/fll_ctrl_chk.sv
module fll_ctrl_chk
    import fll_pkg::*;
#(
    parameter int unsigned CODE_W = 18,
    parameter int unsigned SET_W  = 13,
    parameter int unsigned STEP   = 1
) (
    input logic              ref_clk,
    input logic              ref_rst_n,
    input logic              loop_en,
    input logic              wr_en,
    input logic              wr_sel,
    input logic [CODE_W-1:0] dco_code,
    input logic [SET_W-1:0]  set_q,
    input lp_state_e         state
);
    // R3
    step_bound_chk: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
        ((dco_code - $past(dco_code)) <= CODE_W'(STEP)) ||
        (($past(dco_code) - dco_code) <= CODE_W'(STEP)));

    // R2
    update_from_eval_chk: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
        (dco_code != $past(dco_code)) |-> ($past(state) == LP_EVAL));

    // R7
    hold_when_off_chk: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
        !loop_en |=> $stable(dco_code));

    // R6
    target_commit_chk: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
        !(wr_en && wr_sel) |=> $stable(set_q));

    // R4
    no_wrap_top_chk: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
        (dco_code == '1) |=> (dco_code != '0));

    // R5
    no_wrap_bottom_chk: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
        (dco_code == '0) |=> (dco_code != '1));
endmodule

bind fll_ctrl fll_ctrl_chk #(.CODE_W(CODE_W), .SET_W(SET_W), .STEP(STEP)) u_chk (
    .ref_clk(ref_clk), .ref_rst_n(ref_rst_n), .loop_en(loop_en),
    .wr_en(wr_en), .wr_sel(wr_sel), .dco_code(dco_code),
    .set_q(set_q), .state(lp_state)
);

// File: tb/sim_fll_ctrl.sv
module sim_fll_ctrl;
    timeunit 1ns;
    timeprecision 1fs;

    logic ref_clk = 0, rst_n = 0, osc0 = 0, osc1 = 0;
    logic en0 = 0, wr_en0 = 0, wr_sel0 = 0;
    logic en1 = 0, wr_en1 = 0, wr_sel1 = 0;
    logic [7:0] wd0 = 0, wd1 = 0;
    logic [17:0] dco0;
    logic [7:0]  dco1;

    int tests = 0, fails = 0, oc0 = 0, cyc = 0, last0 = -100;
    int dir1 = 1, dir1_next = 1;
    bit mon_on = 0, u1_done = 0, reported = 0;
    logic [17:0] p0;
    logic [7:0]  p1;

    fll_ctrl u0 (.ref_clk(ref_clk), .ref_rst_n(rst_n), .osc_clk(osc0), .osc_rst_n(rst_n),
        .loop_en(en0), .wr_en(wr_en0), .wr_sel(wr_sel0), .wr_data(wd0), .dco_code(dco0));

    fll_ctrl #(.CODE_W(8), .CODE_RST(128), .SET_RST(8191)) u1 (.ref_clk(ref_clk),
        .ref_rst_n(rst_n), .osc_clk(osc1), .osc_rst_n(rst_n), .loop_en(en1),
        .wr_en(wr_en1), .wr_sel(wr_sel1), .wr_data(wd1), .dco_code(dco1));

    always #5 ref_clk = ~ref_clk;
    always #10 osc1 = ~osc1;

    // oscillator model: cycles per 160 ns window = code / 32
    initial begin
        forever begin
            int c;
            c = $isunknown(dco0) ? 131072 : int'(dco0);
            if (c < 1024) c = 1024;
            #(80.0 * 32.0 / real'(c)) osc0 = ~osc0;
        end
    end
    always @(posedge osc0) oc0++;

    task automatic chk(input bit ok, input string r, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s got %0d expected %0d", r, act, exp);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    // per-cycle reference model
    always @(posedge ref_clk) begin
        #2;
        if (mon_on) begin
            int d0;
            cyc++;
            d0 = int'(dco0) - int'(p0);
            chk(d0 >= -1 && d0 <= 1, "R3 step size", d0, 0);
            if (!en0) chk(d0 == 0, "R7 hold while off", int'(dco0), int'(p0));
            if (d0 != 0) begin
                chk(cyc - last0 >= 15, "R2 one update per window", cyc - last0, 16);
                last0 = cyc;
            end
            chk(dco1 == p1 || int'(dco1) == int'(p1) + dir1, "R3 direction", int'(dco1),
                int'(p1) + dir1);
            p0 = dco0;
            p1 = dco1;
            dir1 = dir1_next;
        end
    end

    task automatic wr0(input logic sel, input logic [7:0] d);
        @(negedge ref_clk); wr_en0 = 1; wr_sel0 = sel; wd0 = d;
        @(negedge ref_clk); wr_en0 = 0;
    endtask

    task automatic wr1(input logic sel, input logic [7:0] d);
        @(negedge ref_clk); wr_en1 = 1; wr_sel1 = sel; wd1 = d;
        @(negedge ref_clk); wr_en1 = 0;
    endtask

    task automatic windows(input int n);
        repeat (n * 16) @(negedge ref_clk);
    endtask

    task automatic measure(input int n, input int tgt, input string r);
        for (int i = 0; i < n; i++) begin
            int a;
            @(negedge ref_clk); a = oc0;
            repeat (16) @(negedge ref_clk);
            chk((oc0 - a - tgt) <= 1 && (oc0 - a - tgt) >= -1, r, oc0 - a, tgt);
        end
    endtask

    // small instance: saturation limits
    initial begin
        wait (mon_on);
        @(negedge ref_clk); en1 = 1;
        windows(160);
        chk(dco1 == 8'hFF, "R4 reach max", int'(dco1), 255);
        windows(10);
        chk(dco1 == 8'hFF, "R4 hold at max", int'(dco1), 255);
        wr1(0, 8'h00);
        windows(4);
        chk(dco1 == 8'hFF, "R6 staged high part inert", int'(dco1), 255);
        @(negedge ref_clk); wr_en1 = 1; wr_sel1 = 1; wd1 = 8'h00; dir1_next = -1;
        @(negedge ref_clk); wr_en1 = 0;
        windows(300);
        chk(dco1 == 8'h00, "R5 reach zero", int'(dco1), 0);
        windows(10);
        chk(dco1 == 8'h00, "R5 hold at zero", int'(dco1), 0);
        u1_done = 1;
    end

    initial begin
        repeat (200000) @(posedge ref_clk);
        chk(0, "R8 watchdog expired", cyc, 0);
        report();
    end

    initial begin
        int c0;
        repeat (3) @(negedge ref_clk);
        chk(dco0 == 18'd131072, "R1 reset code", int'(dco0), 131072);
        chk(dco1 == 8'd128, "R1 reset code small", int'(dco1), 128);
        rst_n = 1;
        p0 = dco0; p1 = dco1; mon_on = 1;
        @(negedge ref_clk); en0 = 1;
        windows(30);
        measure(4, 4096, "R8 lock to reset target");
        c0 = int'(dco0);
        wr0(0, 8'h10);                       // would be 4351 if committed
        windows(20);
        chk(int'(dco0) - c0 <= 8 && c0 - int'(dco0) <= 8, "R6 high write alone", int'(dco0), c0);
        measure(2, 4096, "R6 target unchanged");
        wr0(1, 8'h01);                       // commit 4097 -> target 4098
        windows(120);
        measure(4, 4098, "R8 lock after commit");
        chk(int'(dco0) > c0 + 40, "R6 code moved after commit", int'(dco0), c0 + 64);
        @(negedge ref_clk); en0 = 0;
        c0 = int'(dco0);
        wr0(0, 8'h0F);
        wr0(1, 8'hFF);                       // 4095 -> target 4096
        windows(30);
        chk(int'(dco0) == c0, "R7 frozen while off", int'(dco0), c0);
        @(negedge ref_clk); en0 = 1;
        windows(2);
        chk(int'(dco0) - c0 <= 2 && c0 - int'(dco0) <= 2, "R7 resume from held", int'(dco0), c0);
        windows(100);
        measure(4, 4096, "R8 relock after restart");
        wait (u1_done);
        report();
    end
endmodule